// File: doc/BRIEF.md
# Interrupt Polling and Vectoring Controller

This block sits next to a small microcontroller core and decides when the core's next instruction must be replaced by a hardware long call to an interrupt service routine. The core supplies two phase strobes. One marks the sub-cycle at which most interrupt sources are captured. The other marks an earlier sub-cycle, used by one timer source. The block captures every source into a request flag. Once per machine cycle it polls the flags and applies the enable and priority settings, the in-progress levels and the instruction-boundary rules. When a request wins, it emits a one-clock call request together with the vector address.

There are two priority levels. The block records which levels have an interrupt in progress. That record changes only when a call is issued or when the core signals a return-from-interrupt. When an edge-triggered external request or a timer-0/1 overflow request is acknowledged, its flag is cleared in hardware. Level-style sources are re-captured every machine cycle and never cleared by the block.

Source numbering, which is also the polling order, lowest number first:
- 0: external 0
- 1: timer 0
- 2: external 1
- 3: timer 1
- 4: serial (receive or transmit)
- 5: timer 2 (overflow or external flag)
- 6 and up: additional external inputs 2 to 6

Top module: `irq_vector_ctrl`

## Requirements
- R1: The external pins `ext_n_i[1:0]` are active low. They are inverted and captured on the clock where `s5p2_i` is high. With `ext_edge_i[j]`=0 the flag equals the captured level. With `ext_edge_i[j]`=1 the flag is set when the captured level goes from inactive to active between two successive captures.
- R2: The sources below are captured on an `s5p2_i` clock and take part only in the poll of the next machine cycle, never in the poll of the same clock:
  - the additional external inputs `ext_hi_i` (active high)
  - the serial flags `ser_ri_i` | `ser_ti_i`
  - the timer-2 external flag `t2_ext_i`
- R3: The timer-0/1 overflow pulses `tmr_ovf_i` set their flags on an `s5p2_i` clock and are polled in the next machine cycle. The timer-2 overflow `t2_ovf_i` is captured on the `s2p2_i` clock and polled at the `s5p2_i` clock of the same machine cycle.
- R4: Polling happens only on `s5p2_i` clocks. An accepted request raises `call_o` for exactly the one clock after that edge.
- R5: `vec_o` holds 0x0003 + 8·n for the accepted source n, with n numbered as listed above. `vec_o` keeps its value between calls and resets to 0.
- R6: Pending requests with `ip_i[n]`=1 (high level) win over low-level ones. Within a level, the lowest source number wins.
- R7: A request is pending only when `ea_i`=1 and `ie_i[n]`=1.
- R8: No request is accepted unless `last_cycle_i`=1 and `hold_insn_i`=0 at the polling clock. `hold_insn_i` marks a return-from-interrupt or a write to the enable or priority registers.
- R9: Accepting a request sets `in_prog_o[level]`. While `in_prog_o[1]` is set, no request is accepted. While `in_prog_o[0]` is set, only high-level requests are accepted. Both bits reset to 0.
- R10: A one-clock `reti_i` pulse clears `in_prog_o[1]` if it is set, and otherwise clears `in_prog_o[0]`. Nothing else clears either bit.
- R11: Acceptance clears the flag of an edge-mode external source or of a timer-0/1 source. If a new set arrives on the same clock, the set wins and the flag stays.
- R12: An external pin held low from before the `s5p2_i` clock of machine cycle k, with nothing blocking, produces `call_o` after the `s5p2_i` clock of cycle k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s2p2_i | input | 1 | Early-phase strobe, one clock per machine cycle |
| s5p2_i | input | 1 | Capture and poll strobe, one clock per machine cycle |
| ext_n_i | input | 2 | External interrupt pins 0 and 1, active low |
| ext_edge_i | input | 2 | Edge (1) or level (0) mode for external pins 0 and 1 |
| ext_hi_i | input | N_HI | Additional external request levels, active high |
| tmr_ovf_i | input | 2 | Timer-0/1 overflow pulses |
| t2_ovf_i | input | 1 | Timer-2 overflow flag |
| t2_ext_i | input | 1 | Timer-2 external flag |
| ser_ri_i | input | 1 | Serial receive flag |
| ser_ti_i | input | 1 | Serial transmit flag |
| ea_i | input | 1 | Global interrupt enable |
| ie_i | input | 6+N_HI | Per-source enables |
| ip_i | input | 6+N_HI | Per-source priority, 1 = high |
| last_cycle_i | input | 1 | Current machine cycle ends the instruction |
| hold_insn_i | input | 1 | Current instruction is a return-from-interrupt or an enable/priority write |
| reti_i | input | 1 | Return-from-interrupt pulse |
| call_o | output | 1 | Hardware call request, one clock |
| vec_o | output | VEC_W | Vector address of the last call |
| in_prog_o | output | 2 | In-progress flags per priority level |

## Verification
Two actions can land on the same polling clock: the hardware clear that comes with acknowledging a timer-0 flag, and a fresh overflow that sets that same flag. The bench provokes this by pulsing the timer-0 overflow in two consecutive machine cycles, so the second set coincides with the first acceptance. The outcome is judged after the return: a second call to vector 0x000B must follow, which shows the set won. A second case shares one machine cycle between the timer-2 capture and its poll. A behavioural model compares `call_o`, `vec_o` and `in_prog_o` on every clock, so a capture moved to the wrong phase shows up as a call one cycle off.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_EXT0  = 0;
  localparam int SRC_TMR0  = 1;
  localparam int SRC_EXT1  = 2;
  localparam int SRC_TMR1  = 3;
  localparam int SRC_SER   = 4;
  localparam int SRC_TMR2  = 5;
  localparam int SRC_HI0   = 6;
  localparam int NUM_FIXED = 6;

  typedef enum logic {LVL_LO = 1'b0, LVL_HI = 1'b1} lvl_e;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler
  import irq_pkg::*;
#(
  parameter int N_HI  = 5,
  parameter int N_SRC = NUM_FIXED + N_HI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s2p2_i,
  input  logic             s5p2_i,
  input  logic [1:0]       ext_n_i,
  input  logic [1:0]       ext_edge_i,
  input  logic [N_HI-1:0]  ext_hi_i,
  input  logic [1:0]       tmr_ovf_i,
  input  logic             t2_ovf_i,
  input  logic             t2_ext_i,
  input  logic             ser_ri_i,
  input  logic             ser_ti_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] req_o
);

  // external 0/1 share slots 0/2, timers 0/1 share slots 1/3
  for (genvar j = 0; j < 2; j++) begin : g_pair
    localparam int EXT_IDX = 2 * j;
    localparam int TMR_IDX = 2 * j + 1;
    logic act;
    logic prev_q;
    logic ext_q;
    logic tmr_q;

    assign act = ~ext_n_i[j];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        ext_q  <= 1'b0;
      end else if (s5p2_i) begin
        prev_q <= act;
        if (ext_edge_i[j]) ext_q <= (act & ~prev_q) | (ext_q & ~ack_i[EXT_IDX]);
        else               ext_q <= act;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tmr_q <= 1'b0;
      else if (s5p2_i) tmr_q <= tmr_ovf_i[j] | (tmr_q & ~ack_i[TMR_IDX]);
    end

    assign req_o[EXT_IDX] = ext_q;
    assign req_o[TMR_IDX] = tmr_q;

    a_r11_tmr_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s5p2_i && tmr_ovf_i[j]) |=> req_o[TMR_IDX]);
    a_r1_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s5p2_i && !ext_edge_i[j]) |=> (req_o[EXT_IDX] == $past(!ext_n_i[j])));
  end

  logic ser_q, exf2_q, tf2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q  <= 1'b0;
      exf2_q <= 1'b0;
    end else if (s5p2_i) begin
      ser_q  <= ser_ri_i | ser_ti_i;
      exf2_q <= t2_ext_i;
    end
  end

  // timer-2 overflow captured early so the same cycle's poll sees it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tf2_q <= 1'b0;
    else if (s2p2_i) tf2_q <= t2_ovf_i;
  end

  assign req_o[SRC_SER]  = ser_q;
  assign req_o[SRC_TMR2] = tf2_q | exf2_q;

  for (genvar k = 0; k < N_HI; k++) begin : g_hi
    logic hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hi_q <= 1'b0;
      else if (s5p2_i) hi_q <= ext_hi_i[k];
    end
    assign req_o[SRC_HI0 + k] = hi_q;
  end

  a_r3_tf2_only_s2p2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2p2_i |=> $stable(tf2_q));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 11,
  parameter int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             ea_i,
  input  logic             poll_i,
  input  logic [1:0]       busy_i,
  output logic             grant_o,
  output logic             lvl_o,
  output logic [SRC_W-1:0] src_o
);

  logic [N_SRC-1:0] pend, pend_hi, pend_lo;
  logic [SRC_W-1:0] idx_hi, idx_lo;
  logic             take_hi, take_lo;

  always_comb begin
    pend    = req_i & en_i & {N_SRC{ea_i}};
    pend_hi = pend & prio_i;
    pend_lo = pend & ~prio_i;
  end

  // downward scan: the last hit is the lowest index
  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_hi[i]) idx_hi = SRC_W'(i);
      if (pend_lo[i]) idx_lo = SRC_W'(i);
    end
  end

  always_comb begin
    take_hi = (|pend_hi) && !busy_i[1];
    take_lo = (|pend_lo) && (busy_i == 2'b00);
    grant_o = poll_i && (take_hi || take_lo);
    lvl_o   = take_hi;
    src_o   = take_hi ? idx_hi : idx_lo;
  end

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  lvl_e       set_lvl_i,
  input  logic       reti_i,
  output logic [1:0] busy_o
);

  logic [1:0] busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (reti_i) begin
      if (busy_q[1]) busy_d[1] = 1'b0;
      else           busy_d[0] = 1'b0;
    end
    if (set_i) busy_d[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 2'b00;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  a_r10_hi_clear_only_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o[1]) |-> $past(reti_i));
  a_r10_lo_clear_only_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o[0]) |-> ($past(reti_i) && !$past(busy_o[1])));
  a_r9_set_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && set_lvl_i == LVL_HI) |=> busy_o[1]);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int N_HI      = 5,
  parameter int VEC_W     = 16,
  parameter int VEC_BASE  = 3,
  parameter int VEC_STEP  = 8,
  parameter int N_SRC     = NUM_FIXED + N_HI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s2p2_i,
  input  logic             s5p2_i,
  input  logic [1:0]       ext_n_i,
  input  logic [1:0]       ext_edge_i,
  input  logic [N_HI-1:0]  ext_hi_i,
  input  logic [1:0]       tmr_ovf_i,
  input  logic             t2_ovf_i,
  input  logic             t2_ext_i,
  input  logic             ser_ri_i,
  input  logic             ser_ti_i,
  input  logic             ea_i,
  input  logic [N_SRC-1:0] ie_i,
  input  logic [N_SRC-1:0] ip_i,
  input  logic             last_cycle_i,
  input  logic             hold_insn_i,
  input  logic             reti_i,
  output logic             call_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [1:0]       in_prog_o
);

  localparam int SRC_W = $clog2(N_SRC);

  logic [N_SRC-1:0] req, ack;
  logic [1:0]       busy;
  logic             poll, grant, lvl;
  logic [SRC_W-1:0] src;
  logic [VEC_W-1:0] vec_d;
  logic             call_q;
  logic [VEC_W-1:0] vec_q;

  assign poll = s5p2_i && last_cycle_i && !hold_insn_i;
  assign ack  = grant ? (N_SRC'(1) << src) : '0;

  irq_sampler #(.N_HI(N_HI), .N_SRC(N_SRC)) u_sampler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s2p2_i    (s2p2_i),
    .s5p2_i    (s5p2_i),
    .ext_n_i   (ext_n_i),
    .ext_edge_i(ext_edge_i),
    .ext_hi_i  (ext_hi_i),
    .tmr_ovf_i (tmr_ovf_i),
    .t2_ovf_i  (t2_ovf_i),
    .t2_ext_i  (t2_ext_i),
    .ser_ri_i  (ser_ri_i),
    .ser_ti_i  (ser_ti_i),
    .ack_i     (ack),
    .req_o     (req)
  );

  irq_arbiter #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb (
    .req_i  (req),
    .en_i   (ie_i),
    .prio_i (ip_i),
    .ea_i   (ea_i),
    .poll_i (poll),
    .busy_i (busy),
    .grant_o(grant),
    .lvl_o  (lvl),
    .src_o  (src)
  );

  irq_level_track u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (grant),
    .set_lvl_i(lvl_e'(lvl)),
    .reti_i   (reti_i),
    .busy_o   (busy)
  );

  assign vec_d = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(src);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      call_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      call_q <= grant;
      if (grant) vec_q <= vec_d;
    end
  end

  assign call_o    = call_q;
  assign vec_o     = vec_q;
  assign in_prog_o = busy;

  a_r4_call_on_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> $past(s5p2_i));
  a_r8_call_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> $past(last_cycle_i && !hold_insn_i));
  a_r7_call_needs_ea: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> $past(ea_i));
  a_r9_hi_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_o |-> !$past(in_prog_o[1]));
  a_r4_vec_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !call_o |-> $stable(vec_o));

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_HI  = 5;
  localparam int N_SRC = 6 + N_HI;
  localparam int PH_N  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s2p2 = 1'b0, s5p2 = 1'b0;
  logic [1:0] ext_n = 2'b11, ext_edge = 2'b00, tmr_ovf = 2'b00;
  logic [N_HI-1:0] ext_hi = '0;
  logic t2_ovf = 1'b0, t2_ext = 1'b0, ser_ri = 1'b0, ser_ti = 1'b0;
  logic ea = 1'b1, last_cyc = 1'b1, hold = 1'b0, reti = 1'b0;
  logic [N_SRC-1:0] ie = '1, ip = '0;
  logic call;
  logic [15:0] vec;
  logic [1:0] inprog;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R9";
  int ph = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .s2p2_i(s2p2), .s5p2_i(s5p2),
    .ext_n_i(ext_n), .ext_edge_i(ext_edge), .ext_hi_i(ext_hi),
    .tmr_ovf_i(tmr_ovf), .t2_ovf_i(t2_ovf), .t2_ext_i(t2_ext),
    .ser_ri_i(ser_ri), .ser_ti_i(ser_ti), .ea_i(ea), .ie_i(ie), .ip_i(ip),
    .last_cycle_i(last_cyc), .hold_insn_i(hold), .reti_i(reti),
    .call_o(call), .vec_o(vec), .in_prog_o(inprog)
  );

  // phase strobes: s2p2 at phase 1, s5p2 at phase 4
  always @(negedge clk) begin
    ph   <= (ph + 1) % PH_N;
    s2p2 <= (((ph + 1) % PH_N) == 1);
    s5p2 <= (((ph + 1) % PH_N) == 4);
  end

  // behavioural reference
  bit   m_flag[N_SRC];
  bit   m_prev[2];
  bit   m_tf2;
  bit   m_busy[2];
  bit   m_call;
  int   m_vec;

  function automatic bit m_req(int i);
    if (i == 5) return m_flag[5] || m_tf2;
    return m_flag[i];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[i]) m_flag[i] = 0;
      m_prev = '{0, 0}; m_tf2 = 0; m_busy = '{0, 0}; m_call = 0; m_vec = 0;
    end else begin
      int win; bit acc; bit hi;
      win = -1; acc = 0; hi = 0;
      if (s5p2 && last_cyc && !hold && ea) begin
        if (!m_busy[1])
          for (int i = 0; i < N_SRC; i++) if (win < 0 && ip[i] && ie[i] && m_req(i)) win = i;
        if (win >= 0) begin acc = 1; hi = 1; end
        else if (!m_busy[0] && !m_busy[1]) begin
          for (int i = 0; i < N_SRC; i++) if (win < 0 && !ip[i] && ie[i] && m_req(i)) win = i;
          if (win >= 0) acc = 1;
        end
      end
      if (s5p2) begin
        for (int j = 0; j < 2; j++) begin
          bit a;
          a = !ext_n[j];
          if (ext_edge[j]) m_flag[2*j] = (a && !m_prev[j]) || (m_flag[2*j] && !(acc && win == 2*j));
          else             m_flag[2*j] = a;
          m_prev[j] = a;
          m_flag[2*j+1] = tmr_ovf[j] || (m_flag[2*j+1] && !(acc && win == 2*j+1));
        end
        m_flag[4] = ser_ri || ser_ti;
        m_flag[5] = t2_ext;
        for (int k = 0; k < N_HI; k++) m_flag[6+k] = ext_hi[k];
      end
      if (s2p2) m_tf2 = t2_ovf;
      if (reti) begin
        if (m_busy[1]) m_busy[1] = 0; else m_busy[0] = 0;
      end
      if (acc) begin
        m_busy[hi] = 1;
        m_vec = 3 + 8 * win;
      end
      m_call = acc;
    end
  end

  task automatic check(string r, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_req, int'(call), int'(m_call), "call_o");
    check(cur_req, int'(vec), m_vec, "vec_o");
    check(cur_req, int'(inprog), {30'd0, m_busy[1], m_busy[0]}, "in_prog_o");
  end

  task automatic mc(int n);
    repeat (n * PH_N) @(negedge clk);
  endtask

  task automatic do_reti;
    @(negedge clk) reti = 1'b1;
    @(negedge clk) reti = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    mc(2);
    @(negedge clk) rst_n = 1'b1;
    check("R9", int'(inprog), 0, "reset in_prog_o");
    check("R5", int'(vec), 0, "reset vec_o");
    check("R4", int'(call), 0, "reset call_o");

    // R1 R12: level-mode external 0, vector 0x0003
    cur_req = "R12";
    ext_n[0] = 1'b0; mc(3); ext_n[0] = 1'b1; mc(1);
    cur_req = "R10"; do_reti; mc(2);

    // R8: not the last cycle of an instruction
    cur_req = "R8";
    last_cyc = 1'b0; tmr_ovf[0] = 1'b1; mc(1); tmr_ovf[0] = 1'b0; mc(3);
    last_cyc = 1'b1; mc(2); do_reti; mc(1);
    // R8: return or enable/priority write in progress
    hold = 1'b1; ext_hi[0] = 1'b1; mc(3); hold = 1'b0; mc(2);
    ext_hi[0] = 1'b0; mc(1); do_reti; mc(2);

    // R6: high level beats lower index; R10 clears high first
    cur_req = "R6";
    ip[6] = 1'b1; ext_hi[0] = 1'b1; ext_n[1] = 1'b0; mc(3);
    ext_hi[0] = 1'b0; mc(1); do_reti; mc(3);
    ext_n[1] = 1'b1; mc(1); do_reti; ip = '0; mc(2);
    // R6: same level, lowest source wins (serial 4 before input 8)
    ser_ri = 1'b1; ext_hi[2] = 1'b1; mc(3); ser_ri = 1'b0; mc(1); do_reti; mc(3);
    ext_hi[2] = 1'b0; mc(1); do_reti; mc(2);

    // R9: high level preempts low; low stays blocked; R10 order
    cur_req = "R9";
    ext_hi[1] = 1'b1; mc(3); ext_hi[1] = 1'b0;
    ip[3] = 1'b1; tmr_ovf[1] = 1'b1; mc(1); tmr_ovf[1] = 1'b0; ext_hi[3] = 1'b1; mc(4);
    cur_req = "R10"; mc(3); do_reti; mc(3); do_reti; mc(3);
    ext_hi[3] = 1'b0; mc(1); do_reti; ip = '0; mc(2);

    // R11: edge mode fires once per falling edge
    cur_req = "R11";
    ext_edge[0] = 1'b1; ext_n[0] = 1'b0; mc(4); do_reti; mc(4);
    ext_n[0] = 1'b1; ext_edge[0] = 1'b0; mc(2);
    // R11: timer-0 set coincides with its own acknowledgement
    tmr_ovf[0] = 1'b1; mc(2); tmr_ovf[0] = 1'b0; mc(2); do_reti; mc(3); do_reti; mc(2);

    // R7: global and per-source enables
    cur_req = "R7";
    ea = 1'b0; ext_hi[4] = 1'b1; mc(3);
    ea = 1'b1; ie[10] = 1'b0; mc(3);
    ie[10] = 1'b1; mc(2); ext_hi[4] = 1'b0; mc(1); do_reti; mc(2);

    // R3: timer-2 overflow polled in its own cycle
    cur_req = "R3";
    t2_ovf = 1'b1; mc(1); t2_ovf = 1'b0; mc(2); do_reti; mc(2);

    // R2: serial transmit and timer-2 external flag polled a cycle later
    cur_req = "R2";
    ser_ti = 1'b1; mc(1); ser_ti = 1'b0; mc(2); do_reti; mc(2);
    t2_ext = 1'b1; mc(1); t2_ext = 1'b0; mc(2); do_reti; mc(2);

    // R5: vector held after the call
    cur_req = "R5";
    mc(2);
    check("R5", int'(vec), 16'h002B, "vec_o after timer-2 call");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule